// File: doc/BRIEF.md
# Read Reference Voltage Calibration Engine

This block recalibrates the starting read reference voltage of every erase block in a flash array. Charge leaks out of the cells over time, so the best reference voltage slowly drifts downward. Each time the trigger fires, which is nominally once a day while the array is otherwise idle, the engine visits the blocks one at a time in ascending order. For each block it reads a single reference page. That page is the last page programmed in the block, so it has the shortest retention age. Each read is issued at a chosen voltage code, and the read path returns the raw bit error count for that read.

The engine does not sweep the whole voltage range. It starts from the code already stored for the block in the prediction table. It first probes lower codes one step at a time, then probes higher codes one step at a time. Each direction stops at the first probe that does not improve on the best error count found so far. The winning code is written back into the table as the block's new starting reference. When two codes give equal counts, the higher code wins, so the stored value stays an upper bound on the optimum.

A pause input lets foreground reads take priority. While pause is high, the engine holds off its next read and keeps its search state.

Top module: `vref_cal_engine`

## Requirements
- R1: A one-cycle high on `start_i` while idle begins a pass that visits blocks 0 to NUM_BLK-1 in ascending order, and `busy_o` is high from the cycle after the trigger. A trigger that arrives while a pass is running has no effect: no extra reads, no extra table writes and no extra done pulse.
- R2: Every read request carries the current block on `rd_blk_o` and page REF_PAGE on `rd_page_o` (255 by default).
- R3: The first read for a block uses the code held in the prediction table at that block's address, which the engine fetches from `tbl_rdata_i`.
- R4: Downward probing reads at start-1, start-2, and so on. It continues only while each new error count is strictly lower than the best so far. It never reads below code 0 and is skipped when the start code is 0.
- R5: Upward probing then reads at start+1, start+2, and so on. It continues only while each new count is strictly lower than the best so far. It never reads above the all-ones code and is skipped when the start code is the all-ones code.
- R6: On equal error counts the higher code is kept. A downward tie leaves the current best unchanged and ends downward probing. An upward tie adopts the higher code and ends the search.
- R7: Each block receives exactly one table write, one cycle wide, with `tbl_addr_o` set to the block and `tbl_wdata_o` set to the code with the lowest count under the rule in R6.
- R8: While `pause_i` is high, `rd_req_o` stays low. Once pause is released, the search resumes with its state intact and gives the same results it would have given without the pause.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last block's table write. `busy_o` is low in that cycle and stays low afterwards.
- R10: After reset, `busy_o`, `done_o`, `rd_req_o` and `tbl_we_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Calibration trigger |
| pause_i | input | 1 | Foreground read in progress; hold off further reads |
| rd_req_o | output | 1 | One-cycle read command |
| rd_blk_o | output | BLK_W | Block address of the read |
| rd_page_o | output | PAGE_W | Page address of the read |
| rd_code_o | output | CODE_W | Reference voltage code for the read |
| ecnt_valid_i | input | 1 | Error count is valid |
| ecnt_i | input | ERR_W | Raw bit error count of the last read |
| tbl_addr_o | output | BLK_W | Prediction table address, used for both reading and writing |
| tbl_rdata_i | input | CODE_W | Stored starting code at `tbl_addr_o` |
| tbl_we_o | output | 1 | Prediction table write enable |
| tbl_wdata_o | output | CODE_W | New starting code |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle pass-complete pulse |

## Verification
The bench models the flash as an error curve per block with a valley at a chosen optimum. Blocks are set up so that their optimum lies at the stored code, below it, or above it. This separates the three search outcomes: no move, a downward walk and an upward walk. Some start codes sit at 0 or at the all-ones code, which shows whether probing is clamped at the code range edges. Two blocks have flat valleys, one reached while stepping down and one while stepping up, which exposes which code is chosen on a tie. A second pass starts from the first pass's results and must land on the same codes. The first pass is run with pause windows and a trigger that arrives mid-pass, which shows whether stalls and stray triggers disturb the search.

// File: rtl/vref_cal_pkg.sv
package vref_cal_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_ISSUE,
      ST_WAIT,
      ST_WRITE,
      ST_DONE
   } cal_state_e;

   typedef enum logic [1:0] {
      PH_FIRST,
      PH_DOWN,
      PH_UP
   } cal_phase_e;

endpackage

// File: rtl/vref_step_judge.sv
module vref_step_judge
   import vref_cal_pkg::*;
#(
   parameter int ERR_W    = 12,
   parameter bit TIE_HIGH = 1'b1
) (
   input  cal_phase_e         phase_i,
   input  logic [ERR_W-1:0]   err_i,
   input  logic [ERR_W-1:0]   best_err_i,
   output logic               take_o,
   output logic               go_on_o
);

   logic better;
   logic tie;

   assign better = err_i < best_err_i;
   assign tie    = err_i == best_err_i;

   generate
      if (TIE_HIGH) begin : g_tie_high
         always_comb begin
            unique case (phase_i)
               PH_FIRST: begin take_o = 1'b1;          go_on_o = 1'b1;   end
               PH_DOWN:  begin take_o = better;        go_on_o = better; end
               PH_UP:    begin take_o = better || tie; go_on_o = better; end
               default:  begin take_o = 1'b0;          go_on_o = 1'b0;   end
            endcase
         end
      end else begin : g_tie_low
         always_comb begin
            unique case (phase_i)
               PH_FIRST: begin take_o = 1'b1;          go_on_o = 1'b1;   end
               PH_DOWN:  begin take_o = better || tie; go_on_o = better; end
               PH_UP:    begin take_o = better;        go_on_o = better; end
               default:  begin take_o = 1'b0;          go_on_o = 1'b0;   end
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/vref_best_reg.sv
module vref_best_reg #(
   parameter int CODE_W = 7,
   parameter int ERR_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_i,
   input  logic              first_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [ERR_W-1:0]  err_i,
   output logic [CODE_W-1:0] best_code_o,
   output logic [ERR_W-1:0]  best_err_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_code_o <= '0;
         best_err_o  <= '0;
      end else if (upd_i) begin
         best_code_o <= code_i;
         best_err_o  <= err_i;
      end
   end

   // R4
   best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && !first_i) |-> (err_i <= best_err_o))
      else $error("best error count would rise");

endmodule

// File: rtl/vref_blk_walker.sv
module vref_blk_walker #(
   parameter int NUM_BLK = 1024,
   localparam int BLK_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             adv_i,
   output logic [BLK_W-1:0] blk_o,
   output logic             last_o
);

   generate
      if (NUM_BLK == 1) begin : g_single
         assign blk_o  = '0;
         assign last_o = 1'b1;
      end else begin : g_count
         localparam logic [BLK_W-1:0] LAST_IDX = BLK_W'(NUM_BLK - 1);
         logic [BLK_W-1:0] idx;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     idx <= '0;
            else if (clr_i) idx <= '0;
            else if (adv_i) idx <= idx + 1'b1;
         end

         assign blk_o  = idx;
         assign last_o = idx == LAST_IDX;
      end
   endgenerate

   // R1
   adv_not_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |-> !last_o)
      else $error("advance past last block");

endmodule

// File: rtl/vref_cal_engine.sv
module vref_cal_engine
   import vref_cal_pkg::*;
#(
   parameter int NUM_BLK  = 1024,
   parameter int CODE_W   = 7,
   parameter int ERR_W    = 12,
   parameter int PAGE_W   = 8,
   parameter int REF_PAGE = 255,
   parameter bit TIE_HIGH = 1'b1,
   localparam int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              pause_i,
   output logic              rd_req_o,
   output logic [BLK_W-1:0]  rd_blk_o,
   output logic [PAGE_W-1:0] rd_page_o,
   output logic [CODE_W-1:0] rd_code_o,
   input  logic              ecnt_valid_i,
   input  logic [ERR_W-1:0]  ecnt_i,
   output logic [BLK_W-1:0]  tbl_addr_o,
   input  logic [CODE_W-1:0] tbl_rdata_i,
   output logic              tbl_we_o,
   output logic [CODE_W-1:0] tbl_wdata_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam logic [CODE_W-1:0] CODE_MAX = '1;

   generate
      if (NUM_BLK < 1) begin : g_bad_blk
         $error("NUM_BLK must be at least 1");
      end
      if (CODE_W < 2) begin : g_bad_code
         $error("CODE_W must be at least 2");
      end
      if (REF_PAGE < 0 || REF_PAGE >= (1 << PAGE_W)) begin : g_bad_page
         $error("REF_PAGE does not fit in PAGE_W");
      end
   endgenerate

   cal_state_e        st;
   cal_phase_e        phase;
   logic [CODE_W-1:0] start_code;
   logic [CODE_W-1:0] cur_code;
   logic [BLK_W-1:0]  blk;
   logic              last_blk;
   logic              take;
   logic              go_on;
   logic [CODE_W-1:0] best_code;
   logic [ERR_W-1:0]  best_err;
   logic              at_floor;
   logic              at_ceil;
   logic              start_ceil;
   logic              result;

   assign at_floor   = cur_code == '0;
   assign at_ceil    = cur_code == CODE_MAX;
   assign start_ceil = start_code == CODE_MAX;
   assign result     = (st == ST_WAIT) && ecnt_valid_i;

   vref_step_judge #(
      .ERR_W    (ERR_W),
      .TIE_HIGH (TIE_HIGH)
   ) u_judge (
      .phase_i    (phase),
      .err_i      (ecnt_i),
      .best_err_i (best_err),
      .take_o     (take),
      .go_on_o    (go_on)
   );

   vref_best_reg #(
      .CODE_W (CODE_W),
      .ERR_W  (ERR_W)
   ) u_best (
      .clk         (clk),
      .rst_n       (rst_n),
      .upd_i       (result && take),
      .first_i     (phase == PH_FIRST),
      .code_i      (cur_code),
      .err_i       (ecnt_i),
      .best_code_o (best_code),
      .best_err_o  (best_err)
   );

   vref_blk_walker #(
      .NUM_BLK (NUM_BLK)
   ) u_walk (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  ((st == ST_IDLE) && start_i),
      .adv_i  ((st == ST_WRITE) && !last_blk),
      .blk_o  (blk),
      .last_o (last_blk)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         phase      <= PH_FIRST;
         start_code <= '0;
         cur_code   <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (start_i) st <= ST_LOAD;
            ST_LOAD: begin
               start_code <= tbl_rdata_i;
               cur_code   <= tbl_rdata_i;
               phase      <= PH_FIRST;
               st         <= ST_ISSUE;
            end
            ST_ISSUE: if (!pause_i) st <= ST_WAIT;
            ST_WAIT: if (ecnt_valid_i) begin
               unique case (phase)
                  PH_FIRST: begin
                     if (!at_floor) begin
                        phase    <= PH_DOWN;
                        cur_code <= cur_code - 1'b1;
                        st       <= ST_ISSUE;
                     end else if (!at_ceil) begin
                        phase    <= PH_UP;
                        cur_code <= cur_code + 1'b1;
                        st       <= ST_ISSUE;
                     end else begin
                        st <= ST_WRITE;
                     end
                  end
                  PH_DOWN: begin
                     if (go_on && !at_floor) begin
                        cur_code <= cur_code - 1'b1;
                        st       <= ST_ISSUE;
                     end else if (!start_ceil) begin
                        phase    <= PH_UP;
                        cur_code <= start_code + 1'b1;
                        st       <= ST_ISSUE;
                     end else begin
                        st <= ST_WRITE;
                     end
                  end
                  PH_UP: begin
                     if (go_on && !at_ceil) begin
                        cur_code <= cur_code + 1'b1;
                        st       <= ST_ISSUE;
                     end else begin
                        st <= ST_WRITE;
                     end
                  end
                  default: st <= ST_WRITE;
               endcase
            end
            ST_WRITE: st <= last_blk ? ST_DONE : ST_LOAD;
            ST_DONE:  st <= ST_IDLE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   assign rd_req_o    = (st == ST_ISSUE) && !pause_i;
   assign rd_blk_o    = blk;
   assign rd_page_o   = PAGE_W'(REF_PAGE);
   assign rd_code_o   = cur_code;
   assign tbl_addr_o  = blk;
   assign tbl_we_o    = st == ST_WRITE;
   assign tbl_wdata_o = best_code;
   assign busy_o      = (st != ST_IDLE) && (st != ST_DONE);
   assign done_o      = st == ST_DONE;

   // R8
   pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_ISSUE) && pause_i) |=> ((st == ST_ISSUE) && $stable(cur_code)))
      else $error("search state moved during pause");

   // R4
   down_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && (phase == PH_DOWN)) |-> (cur_code < start_code))
      else $error("downward probe not below start");

   // R5
   up_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && (phase == PH_UP)) |-> (cur_code > start_code))
      else $error("upward probe not above start");

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o))
      else $error("done longer than one cycle");

   // R7
   write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_we_o |=> !tbl_we_o)
      else $error("table write longer than one cycle");

endmodule

// File: tb/sim_vref_cal_engine.sv
module sim_vref_cal_engine;

   localparam int NB     = 8;
   localparam int CW     = 6;
   localparam int EW     = 8;
   localparam int PW     = 8;
   localparam int BW     = 3;
   localparam int CMAX   = 63;
   localparam int LAT    = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start_i;
   logic          pause_i;
   logic          rd_req;
   logic [BW-1:0] rd_blk;
   logic [PW-1:0] rd_page;
   logic [CW-1:0] rd_code;
   logic          ecnt_valid;
   logic [EW-1:0] ecnt;
   logic [BW-1:0] tbl_addr;
   logic [CW-1:0] tbl_rdata;
   logic          tbl_we;
   logic [CW-1:0] tbl_wdata;
   logic          busy;
   logic          done;

   logic [CW-1:0] tbl_mem [NB];
   int            mdl_tbl [NB];
   int            opt     [NB];
   bit            tie     [NB];

   int exp_rd_q [$];
   int exp_wr_q [$];

   int n_chk = 0;
   int n_err = 0;
   int done_cnt = 0;
   int pause_viol = 0;
   int wr_cnt = 0;

   always #10 clk = ~clk;

   assign tbl_rdata = tbl_mem[tbl_addr];

   vref_cal_engine #(
      .NUM_BLK  (NB),
      .CODE_W   (CW),
      .ERR_W    (EW),
      .PAGE_W   (PW),
      .REF_PAGE (255)
   ) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .pause_i      (pause_i),
      .rd_req_o     (rd_req),
      .rd_blk_o     (rd_blk),
      .rd_page_o    (rd_page),
      .rd_code_o    (rd_code),
      .ecnt_valid_i (ecnt_valid),
      .ecnt_i       (ecnt),
      .tbl_addr_o   (tbl_addr),
      .tbl_rdata_i  (tbl_rdata),
      .tbl_we_o     (tbl_we),
      .tbl_wdata_o  (tbl_wdata),
      .busy_o       (busy),
      .done_o       (done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int err_of(input int b, input int c);
      int d;
      d = (c > opt[b]) ? c - opt[b] : opt[b] - c;
      if (tie[b] && c == opt[b] + 1) return 2;
      return d * 3 + 2;
   endfunction

   // driver: expected reads and write for one block (R3, R4, R5, R6)
   task automatic plan_block(input int b, input int s);
      int best;
      int be;
      int cur;
      int e;
      best = s;
      be   = err_of(b, s);
      exp_rd_q.push_back(b * 256 + s);
      cur = s;
      while (cur > 0) begin
         cur--;
         exp_rd_q.push_back(b * 256 + cur);
         e = err_of(b, cur);
         if (e < be) begin best = cur; be = e; end
         else break;
      end
      cur = s;
      while (cur < CMAX) begin
         cur++;
         exp_rd_q.push_back(b * 256 + cur);
         e = err_of(b, cur);
         if (e < be) begin best = cur; be = e; end
         else begin
            if (e == be) best = cur;
            break;
         end
      end
      exp_wr_q.push_back(b * 256 + best);
      mdl_tbl[b] = best;
   endtask

   // flash model: returns error count LAT cycles after a request
   initial begin
      ecnt_valid = 1'b0;
      ecnt = '0;
      forever begin
         @(negedge clk);
         ecnt_valid = 1'b0;
         #2;
         if (rst_n && rd_req) begin
            automatic int b = int'(rd_blk);
            automatic int c = int'(rd_code);
            repeat (LAT) @(negedge clk);
            ecnt = EW'(err_of(b, c));
            ecnt_valid = 1'b1;
         end
      end
   end

   // monitor: pop and compare scoreboard entries
   initial begin
      bit prev_done = 1'b0;
      forever begin
         @(negedge clk);
         #2;
         if (rst_n) begin
            if (prev_done) chk(!done && !busy, "R9 done one cycle, busy low", int'(done), 0);
            prev_done = done;
            if (pause_i && rd_req) pause_viol++;
            if (rd_req) begin
               chk(rd_page == 8'd255, "R2 read page", int'(rd_page), 255);
               if (exp_rd_q.size() == 0) begin
                  chk(1'b0, "R1 unexpected read", int'(rd_blk) * 256 + int'(rd_code), -1);
               end else begin
                  automatic int x = exp_rd_q.pop_front();
                  chk(x == int'(rd_blk) * 256 + int'(rd_code), "R3/R4/R5 read blk*256+code",
                      int'(rd_blk) * 256 + int'(rd_code), x);
               end
            end
            if (tbl_we) begin
               wr_cnt++;
               tbl_mem[tbl_addr] = tbl_wdata;
               if (exp_wr_q.size() == 0) begin
                  chk(1'b0, "R7 unexpected write", int'(tbl_addr) * 256 + int'(tbl_wdata), -1);
               end else begin
                  automatic int y = exp_wr_q.pop_front();
                  chk(y == int'(tbl_addr) * 256 + int'(tbl_wdata), "R6/R7 write blk*256+code",
                      int'(tbl_addr) * 256 + int'(tbl_wdata), y);
               end
            end
            if (done) begin
               done_cnt++;
               chk(exp_wr_q.size() == 0, "R9 done after last write", exp_wr_q.size(), 0);
            end
         end
      end
   end

   task automatic pulse_start();
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      #2;
   endtask

   task automatic pause_seq();
      repeat (6) @(negedge clk);
      pause_i = 1'b1;
      repeat (12) @(negedge clk);
      pause_i = 1'b0;
      repeat (20) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (5) @(negedge clk);
      pause_i = 1'b1;
      repeat (7) @(negedge clk);
      pause_i = 1'b0;
   endtask

   // watchdog built into the wait
   task automatic wait_done(input int target);
      int cyc = 0;
      while (done_cnt < target && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      if (done_cnt < target) chk(1'b0, "R9 watchdog expired", done_cnt, target);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      rst_n   = 1'b0;
      start_i = 1'b0;
      pause_i = 1'b0;
      tbl_mem[0] = 6'd20; opt[0] = 20; tie[0] = 1'b0;
      tbl_mem[1] = 6'd30; opt[1] = 27; tie[1] = 1'b0;
      tbl_mem[2] = 6'd10; opt[2] = 12; tie[2] = 1'b0;
      tbl_mem[3] = 6'd0;  opt[3] = 0;  tie[3] = 1'b0;
      tbl_mem[4] = 6'd61; opt[4] = 63; tie[4] = 1'b0;
      tbl_mem[5] = 6'd43; opt[5] = 40; tie[5] = 1'b1;
      tbl_mem[6] = 6'd50; opt[6] = 50; tie[6] = 1'b1;
      tbl_mem[7] = 6'd1;  opt[7] = 0;  tie[7] = 1'b0;
      repeat (3) @(negedge clk);
      #2;
      // R10 reset state
      chk(!busy,   "R10 busy after reset",   int'(busy), 0);
      chk(!done,   "R10 done after reset",   int'(done), 0);
      chk(!rd_req, "R10 rd_req after reset", int'(rd_req), 0);
      chk(!tbl_we, "R10 we after reset",     int'(tbl_we), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // pass 1 with pauses and a stray trigger
      for (int b = 0; b < NB; b++) plan_block(b, int'(tbl_mem[b]));
      pulse_start();
      chk(busy, "R1 busy after trigger", int'(busy), 1);
      fork
         pause_seq();
         wait_done(1);
      join
      chk(done_cnt == 1, "R1 one pass per trigger", done_cnt, 1);
      chk(wr_cnt == NB, "R7 one write per block", wr_cnt, NB);
      chk(exp_rd_q.size() == 0, "R4/R5 all reads seen", exp_rd_q.size(), 0);
      chk(pause_viol == 0, "R8 no read while paused", pause_viol, 0);
      for (int b = 0; b < NB; b++)
         chk(int'(tbl_mem[b]) == mdl_tbl[b], "R7 table after pass 1", int'(tbl_mem[b]), mdl_tbl[b]);
      chk(mdl_tbl[5] == 41, "R6 downward tie keeps higher", int'(tbl_mem[5]), 41);
      chk(mdl_tbl[6] == 51, "R6 upward tie adopts higher", int'(tbl_mem[6]), 51);

      // pass 2 from the learned starting points
      for (int b = 0; b < NB; b++) plan_block(b, int'(tbl_mem[b]));
      pulse_start();
      chk(busy, "R1 busy on second pass", int'(busy), 1);
      wait_done(2);
      chk(done_cnt == 2, "R9 second done", done_cnt, 2);
      chk(wr_cnt == 2 * NB, "R7 writes after pass 2", wr_cnt, 2 * NB);
      chk(exp_rd_q.size() == 0, "R3 all reads seen pass 2", exp_rd_q.size(), 0);
      for (int b = 0; b < NB; b++)
         chk(int'(tbl_mem[b]) == mdl_tbl[b], "R7 table after pass 2", int'(tbl_mem[b]), mdl_tbl[b]);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule